// File: doc/BRIEF.md
# Multiphase Oversampling Edge Time-Tag Channel

This block gives each rising edge of one asynchronous input a fine time inside a period of the main clock. The input is sampled at eight points spread evenly across that period. Four phase clocks run at the main frequency and are spaced one eighth of a period apart. Their rising edges give the first four sample points and their falling edges give the other four. Each sample is held in a register on its own phase clock. All eight are then collected into one word on the phase-0 main clock.

A decoder looks at the collected word, together with the newest sample of the period before. It finds the first place where the level goes from low to high and turns that position into a bin index. The result comes out as a one-cycle event strobe and a bin code in the main clock domain. A coarse counter outside this block can then append its own count to make a full timestamp. Clock generation, input conditioning and correction of unequal bin widths are handled elsewhere.

Top module: `phase_tag_channel`

## Requirements
- R1: While reset is asserted, and afterwards until a rising edge has been decoded, `eventValid` is 0 and `fineCode` is 0.
- R2: Sample lane j is taken j/8 of a period after the phase-0 rising edge. Lanes 0 to 3 are taken on the rising edges of `phaseClk[0..3]`, where `phaseClk[k]` lags `phaseClk[0]` by k/8 of a period. Lanes 4 to 7 are taken on the falling edges of the same four clocks.
- R3: When the input rises after the instant of lane j-1 and no later than the instant of lane j, `fineCode` equals j. For j = 0, the edge lies between lane 7 of the previous period and the phase-0 edge.
- R4: For a rising edge inside the sampling period that starts at phase-0 edge E, `eventValid` is high in exactly the one main-clock cycle that follows edge E + 2 periods.
- R5: A falling edge, or an input that stays at a steady level, produces no event.
- R6: If the input is high while reset is released, no event is reported until the input has gone low and then high again.
- R7: When the input rises more than once within one sampling period, a single event is reported, and it carries the code of the earliest rise.
- R8: Rising edges in two consecutive periods are reported in two consecutive cycles, each with its own code. The last sample of a period serves as the reference level for lane 0 of the next period.
- R9: `fineCode` is 0 in every cycle in which `eventValid` is 0.
- R10: A pulse that starts and ends between two adjacent sample instants produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkMain | input | 1 | Phase-0 main clock; output and retiming domain |
| phaseClk | input | PHASES | Sampling clocks; bit k lags phase 0 by k/(2*PHASES) of a period |
| rst | input | 1 | Asynchronous active-high reset for all domains |
| hitIn | input | 1 | Asynchronous input whose rising edges are tagged |
| fineCode | output | $clog2(2*PHASES) | Bin index of the earliest rising edge in the decoded period |
| eventValid | output | 1 | One-cycle strobe marking a decoded rising edge |

## Verification
The bench places a single rising edge in each of the eight bins in turn. This sweep separates a lane that is wired to the wrong clock or the wrong edge, and a wrong priority order, from correct behaviour, because each wrong case shows up as a distinct code. It also checks the cycle before and the cycle after the expected cycle, which pins down the latency. Every pair of rise, fall, rise patterns inside one period tests that only the first edge is kept. Other runs cover edges in back-to-back periods, pulses that are narrower than a bin, falling edges, and an input that is already high at reset. Together these show whether the edge reference is taken from the previous sample, including the last sample of the period before, or wrongly from the same lane one cycle earlier.

// File: rtl/tag_pkg.sv
package tag_pkg;

  // Number of phase clocks; each contributes a rising and a falling sample.
  localparam int unsigned PHASE_CLOCKS = 4;

  // Strobes handed from the edge decoder to the datapath registers.
  typedef struct packed {
    logic fire;        // a low-to-high step was found in the decoded word
    logic newestHigh;  // level of the latest sample, kept as next reference
  } tagStrobeT;

endpackage

// File: rtl/tag_phase_lanes.sv
module tag_phase_lanes #(
  parameter int unsigned PHASES = tag_pkg::PHASE_CLOCKS
) (
  input  logic [PHASES-1:0]   phaseClk,
  input  logic                rst,
  input  logic                hitIn,
  output logic [2*PHASES-1:0] laneSample
);

  localparam int unsigned LANES = 2 * PHASES;

  // Lane j fires j/LANES of a period after phase 0: the first half on
  // rising edges, the second half on falling edges of the same clocks.
  // Reset preloads a high level so that no step can be seen at release.
  for (genvar j = 0; j < LANES; j++) begin : gLane
    localparam int unsigned SRC = j % PHASES;
    logic q;
    if (j < PHASES) begin : gRise
      always_ff @(posedge phaseClk[SRC] or posedge rst) begin
        if (rst) q <= 1'b1;
        else     q <= hitIn;
      end
    end else begin : gFall
      always_ff @(negedge phaseClk[SRC] or posedge rst) begin
        if (rst) q <= 1'b1;
        else     q <= hitIn;
      end
    end
    assign laneSample[j] = q;
  end

endmodule

// File: rtl/tag_edge_ctrl.sv
module tag_edge_ctrl
  import tag_pkg::*;
#(
  parameter int unsigned PHASES = tag_pkg::PHASE_CLOCKS
) (
  input  logic [2*PHASES-1:0]         bankWord,
  input  logic                        historyBit,
  output tagStrobeT                   strobe,
  output logic [$clog2(2*PHASES)-1:0] firstCode
);

  localparam int unsigned LANES  = 2 * PHASES;
  localparam int unsigned CODE_W = $clog2(LANES);

  logic [LANES-1:0] priorLevel;
  logic [LANES-1:0] riseMask;

  // Each sample is compared with the one taken just before it in time.
  assign priorLevel = {bankWord[LANES-2:0], historyBit};
  assign riseMask   = bankWord & ~priorLevel;

  // Lowest lane wins: scan downward so the earliest step is written last.
  always_comb begin
    firstCode = '0;
    for (int j = LANES - 1; j >= 0; j--) begin
      if (riseMask[j]) firstCode = CODE_W'(j);
    end
  end

  assign strobe.fire       = |riseMask;
  assign strobe.newestHigh = bankWord[LANES-1];

endmodule

// File: rtl/tag_datapath.sv
module tag_datapath
  import tag_pkg::*;
#(
  parameter int unsigned PHASES = tag_pkg::PHASE_CLOCKS
) (
  input  logic                        clkMain,
  input  logic [PHASES-1:0]           phaseClk,
  input  logic                        rst,
  input  logic                        hitIn,
  input  tagStrobeT                   strobe,
  input  logic [$clog2(2*PHASES)-1:0] firstCode,
  output logic [2*PHASES-1:0]         bankWord,
  output logic                        historyBit,
  output logic [$clog2(2*PHASES)-1:0] fineCode,
  output logic                        eventValid
);

  localparam int unsigned LANES = 2 * PHASES;

  logic [LANES-1:0] laneSample;

  tag_phase_lanes #(.PHASES(PHASES)) uLanes (
    .phaseClk  (phaseClk),
    .rst       (rst),
    .hitIn     (hitIn),
    .laneSample(laneSample)
  );

  // Retiming bank: every lane has at least one bin of slack to phase 0.
  always_ff @(posedge clkMain or posedge rst) begin
    if (rst) bankWord <= '1;
    else     bankWord <= laneSample;
  end

  // Reference level and registered result.
  always_ff @(posedge clkMain or posedge rst) begin
    if (rst) begin
      historyBit <= 1'b1;
      eventValid <= 1'b0;
      fineCode   <= '0;
    end else begin
      historyBit <= strobe.newestHigh;
      eventValid <= strobe.fire;
      fineCode   <= strobe.fire ? firstCode : '0;
    end
  end

endmodule

// File: rtl/phase_tag_channel.sv
module phase_tag_channel
  import tag_pkg::*;
#(
  parameter int unsigned PHASES = tag_pkg::PHASE_CLOCKS
) (
  input  logic                        clkMain,
  input  logic [PHASES-1:0]           phaseClk,
  input  logic                        rst,
  input  logic                        hitIn,
  output logic [$clog2(2*PHASES)-1:0] fineCode,
  output logic                        eventValid
);

  localparam int unsigned LANES  = 2 * PHASES;
  localparam int unsigned CODE_W = $clog2(LANES);

  tagStrobeT         strobe;
  logic [LANES-1:0]  bankWord;
  logic              historyBit;
  logic [CODE_W-1:0] firstCode;

  tag_edge_ctrl #(.PHASES(PHASES)) uCtrl (
    .bankWord  (bankWord),
    .historyBit(historyBit),
    .strobe    (strobe),
    .firstCode (firstCode)
  );

  tag_datapath #(.PHASES(PHASES)) uPath (
    .clkMain   (clkMain),
    .phaseClk  (phaseClk),
    .rst       (rst),
    .hitIn     (hitIn),
    .strobe    (strobe),
    .firstCode (firstCode),
    .bankWord  (bankWord),
    .historyBit(historyBit),
    .fineCode  (fineCode),
    .eventValid(eventValid)
  );

endmodule

// File: rtl/tag_channel_checks.sv
module tag_channel_checks #(
  parameter int unsigned PHASES = tag_pkg::PHASE_CLOCKS
) (
  input logic                        clkMain,
  input logic                        rst,
  input logic [2*PHASES-1:0]         bankWord,
  input logic                        historyBit,
  input logic [$clog2(2*PHASES)-1:0] fineCode,
  input logic                        eventValid
);

  localparam int unsigned LANES = 2 * PHASES;

  // Copies of the word that the registered result was decoded from.
  logic [LANES-1:0] seenBank;
  logic             seenHistory;
  logic             lowBefore;

  always_ff @(posedge clkMain or posedge rst) begin
    if (rst) begin
      seenBank    <= '1;
      seenHistory <= 1'b1;
    end else begin
      seenBank    <= bankWord;
      seenHistory <= historyBit;
    end
  end

  always_comb begin
    if (fineCode == '0) lowBefore = !seenHistory;
    else                lowBefore = !seenBank[fineCode - 1'b1];
  end

  // R9: code is cleared whenever there is no event
  assert_idle_code_R9: assert property (@(posedge clkMain) disable iff (rst)
    !eventValid |-> fineCode == '0);

  // R3: the reported bin holds a high sample
  assert_bin_high_R3: assert property (@(posedge clkMain) disable iff (rst)
    eventValid |-> seenBank[fineCode]);

  // R8: the sample just before the reported bin (history for bin 0) was low
  assert_low_before_R8: assert property (@(posedge clkMain) disable iff (rst)
    eventValid |-> lowBefore);

  // R5: an all-low period yields no event
  assert_quiet_low_R5: assert property (@(posedge clkMain) disable iff (rst)
    (seenBank == '0) |-> !eventValid);

endmodule

bind phase_tag_channel tag_channel_checks #(.PHASES(PHASES)) uChecks (
  .clkMain   (clkMain),
  .rst       (rst),
  .bankWord  (bankWord),
  .historyBit(historyBit),
  .fineCode  (fineCode),
  .eventValid(eventValid)
);

// File: tb/tb_phase_tag_channel.sv
`timescale 1ns/1ps
module tb_phase_tag_channel;

  localparam int unsigned PHASES = 4;
  localparam int unsigned LANES  = 2 * PHASES;
  localparam realtime     PERIOD = 20.0;
  localparam realtime     STEP   = PERIOD / LANES;

  logic              clkMain;
  logic [PHASES-1:0] phaseClk;
  logic              rst;
  logic              hitIn;
  logic [2:0]        fineCode;
  logic              eventValid;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  phase_tag_channel #(.PHASES(PHASES)) dut (
    .clkMain(clkMain), .phaseClk(phaseClk), .rst(rst), .hitIn(hitIn),
    .fineCode(fineCode), .eventValid(eventValid)
  );

  // All clocks from one process; phase k lags phase 0 by k steps.
  initial begin
    int s = 4;
    forever begin
      clkMain = (s < 4);
      for (int k = 0; k < PHASES; k++) phaseClk[k] = (((s - k + 8) % 8) < 4);
      #(STEP);
      s = (s + 1) % 8;
    end
  end

  task automatic waitUntil(input realtime t);
    if (t > $realtime) #(t - $realtime);
  endtask

  task automatic expectAt(input realtime t, input string req, input int expEv, input int expCode);
    waitUntil(t);
    total++;
    if (eventValid !== expEv[0] || fineCode !== expCode[2:0]) begin
      bad++;
      $display("FAIL %s at %0t: actual ev=%0b code=%0d expected ev=%0d code=%0d",
               req, $realtime, eventValid, fineCode, expEv, expCode);
    end
  endtask

  // Start of the next sampling period (one period after the next phase-0 edge).
  task automatic nextWindow(output realtime e);
    @(posedge clkMain);
    e = $realtime + PERIOD;
  endtask

  function automatic realtime binTime(input realtime e, input int j);
    return e + STEP * j - STEP / 2;
  endfunction

  // Drop the input and confirm that nothing is reported (R5).
  task automatic fallQuiet(input realtime e);
    waitUntil(e + 3 * PERIOD + 10.0);
    hitIn = 0;
    for (int c = 4; c < 7; c++) expectAt(e + c * PERIOD + 6.25, "R5 falling edge", 0, 0);
  endtask

  task automatic singleRise(input int j, input string req);
    realtime e;
    nextWindow(e);
    waitUntil(binTime(e, j));
    hitIn = 1;
    expectAt(e + PERIOD + 6.25, "R4 before", 0, 0);
    expectAt(e + 2 * PERIOD + 6.25, req, 1, j);
    expectAt(e + 3 * PERIOD + 6.25, "R4 after", 0, 0);
    fallQuiet(e);
  endtask

  initial begin
    realtime e;
    rst = 1;
    hitIn = 1;
    waitUntil(101.25);
    expectAt(101.25, "R1 in reset", 0, 0);
    waitUntil(201.25);
    rst = 0;
    // R6: input high across reset release gives no event
    for (int c = 0; c < 6; c++) expectAt(206.25 + c * PERIOD, "R6 high at reset", 0, 0);
    hitIn = 0;
    expectAt($realtime + 3 * PERIOD, "R1 after release", 0, 0);
    singleRise(2, "R6 first real rise");

    // R2 R3 R4: one edge in every bin
    for (int j = 0; j < LANES; j++) singleRise(j, "R2 R3 bin sweep");

    // R7: rise, fall, rise within one period keeps the first
    for (int a = 0; a < LANES - 2; a++) begin
      for (int b = a + 2; b < LANES; b++) begin
        nextWindow(e);
        waitUntil(binTime(e, a));     hitIn = 1;
        waitUntil(binTime(e, a + 1)); hitIn = 0;
        waitUntil(binTime(e, b));     hitIn = 1;
        expectAt(e + PERIOD + 6.25, "R7 before", 0, 0);
        expectAt(e + 2 * PERIOD + 6.25, "R7 earliest edge", 1, a);
        expectAt(e + 3 * PERIOD + 6.25, "R7 single event", 0, 0);
        fallQuiet(e);
      end
    end

    // R8: edges in consecutive periods, including a bin-0 step
    nextWindow(e);
    waitUntil(binTime(e, 6));          hitIn = 1;
    waitUntil(binTime(e + PERIOD, 1)); hitIn = 0;
    waitUntil(binTime(e + PERIOD, 4)); hitIn = 1;
    expectAt(e + 2 * PERIOD + 6.25, "R8 first period", 1, 6);
    expectAt(e + 3 * PERIOD + 6.25, "R8 second period", 1, 4);
    expectAt(e + 4 * PERIOD + 6.25, "R8 after", 0, 0);
    waitUntil(e + 4 * PERIOD + 10.0);
    hitIn = 0;
    nextWindow(e);
    waitUntil(binTime(e, 7));          hitIn = 1;
    waitUntil(binTime(e + PERIOD, 0) - 0.5); hitIn = 0;
    waitUntil(binTime(e + PERIOD, 0)); hitIn = 1;
    expectAt(e + 2 * PERIOD + 6.25, "R8 bin 7", 1, 7);
    expectAt(e + 3 * PERIOD + 6.25, "R8 bin 0 after bin 7", 0, 0);
    fallQuiet(e);

    // R10: pulse between two sample instants is not seen
    for (int j = 1; j < LANES; j++) begin
      nextWindow(e);
      waitUntil(binTime(e, j) - 0.6); hitIn = 1;
      waitUntil(binTime(e, j) + 0.6); hitIn = 0;
      expectAt(e + 2 * PERIOD + 6.25, "R10 narrow pulse", 0, 0);
      expectAt(e + 3 * PERIOD + 6.25, "R10 narrow pulse after", 0, 0);
    end

    // R9: idle code stays zero over a quiet stretch
    for (int c = 0; c < 4; c++) expectAt($realtime + PERIOD, "R9 idle code", 0, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(2_000_000.0);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule